// File: doc/BRIEF.md
# Flash Read ECC Error Handler

This block sits on the read path of an embedded flash controller. It receives each raw 64-bit flash word together with its 8 check bits and a 4-bit integrity value, and it returns the response data one cycle later. When error checking is enabled for the region being read, single-bit errors are repaired without any visible effect. A double-bit error, or an integrity mismatch found after repair, comes back as an in-band error on the response. The same event raises an alert and records the failing address for software.

The alert policy is chosen by an input. In fatal mode an alert stays set until reset, while reads keep being served. In recoverable mode software clears the uncorrectable flag with a one-cycle clear strobe, and that strobe also drops the alert. This lets boot code reject a corrupted image slot and go on to the other slot without resetting the chip. A saturating counter records how many corrections have taken place.

Top module: `flash_rd_ecc`

## Requirements
- R1: A read presented with `rd_valid` high at a clock edge produces `rsp_valid` high, along with its `rsp_data` and `rsp_err`, right after that edge. In every other cycle `rsp_valid` and `rsp_err` are low, and `rsp_data` holds the last response.
- R2: The code is a (72,64) Hsiao code. The column for data bit i is the i-th 8-bit value in ascending numeric order, taken first from the values of weight 3 and then from the values of weight 5. Check bit j has the one-hot column j. Check bit j is the XOR of every data bit whose column has bit j set. The syndrome is the recomputed check XOR the stored check. When the syndrome equals a data column, that data bit is flipped. When it is one-hot, the data is returned unchanged. In both cases `rsp_err` stays low.
- R3: When checking is enabled and the syndrome is nonzero but matches no column (any even weight, or an odd weight that is not used), the response has `rsp_err`=1 and `rsp_data`=0, and an uncorrectable event is recorded.
- R4: With `ecc_en`=0, `rsp_data` equals `raw_data` as presented, corrupted or not. `rsp_err` stays low, and the alert, flag, address and count do not change.
- R5: The expected integrity value is the XOR of the eight 4-bit nibbles of (bits 31:0 XOR bits 63:32) of the corrected data. When it differs from `raw_icv`, the read is treated as in R3. A single-bit error whose integrity value was computed over the correct data is therefore not an error.
- R6: With `alert_mode`=0 (fatal), an uncorrectable event sets `alert`, and `alert` stays high until reset. `sw_clr` does not clear it, and reads are still served normally.
- R7: With `alert_mode`=1 (recoverable), `alert` stays high after an uncorrectable event until a `sw_clr` cycle clears it. The clear only works if no event has been recorded in fatal mode since reset. A new event in the same cycle as the clear wins.
- R8: `uncorr_flag` is set by every uncorrectable event and is cleared by `sw_clr` in either mode. A new event in the same cycle keeps it set.
- R9: `corr_cnt` counts the ecc-enabled reads that had a single-bit error (R2). It saturates at 255 and only reset clears it.
- R10: `err_addr` captures `rd_addr` of an uncorrectable read when `uncorr_flag` is clear, or when `sw_clr` is high in that cycle. Otherwise it holds the first failing address.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_valid | input | 1 | Raw word valid this cycle |
| rd_addr | input | ADDR_W | Address of the read |
| ecc_en | input | 1 | Error checking enabled for the region |
| raw_data | input | 64 | Raw data word from the array |
| raw_chk | input | 8 | Stored SECDED check bits |
| raw_icv | input | 4 | Stored integrity value |
| alert_mode | input | 1 | 0 fatal sticky alert, 1 recoverable alert |
| sw_clr | input | 1 | Write-1-to-clear strobe for the uncorrectable flag |
| rsp_valid | output | 1 | Response valid |
| rsp_data | output | 64 | Response data |
| rsp_err | output | 1 | In-band access error |
| alert | output | 1 | Uncorrectable error alert |
| corr_cnt | output | 8 | Saturating correctable-error count |
| uncorr_flag | output | 1 | Uncorrectable error flag |
| err_addr | output | ADDR_W | Address of the first uncorrectable read |

## Verification
The per-cycle properties cover the following: a response follows every read by one cycle, every error response comes with the alert and the flag, pass-through holds when checking is disabled, and a fatal alert never drops. They also cover the clear of the flag, the hold of the captured address and the monotonic, saturating counter. The following can only be shown by the bench's scenarios, against a model that finds the single flipped bit by brute force: whether a given corrupted word is repaired or rejected, and that the integrity value is judged after repair. The same applies to how recoverable and fatal clears behave, to a clear colliding with a new error, and to saturation after hundreds of corrections.

// File: rtl/flash_rd_ecc_pkg.sv
package flash_rd_ecc_pkg;
    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int ICV_W  = 4;
    localparam int HALF_W = DATA_W / 2;
    localparam int NIB_N  = HALF_W / ICV_W;

    typedef logic [DATA_W-1:0]            data_t;
    typedef logic [CHK_W-1:0]             chk_t;
    typedef logic [ICV_W-1:0]             icv_t;
    typedef logic [DATA_W-1:0][CHK_W-1:0] cols_t;

    // Odd-weight columns, lowest weight first, ascending value within a weight.
    function automatic cols_t hsiao_cols();
        cols_t c = '0;
        int    n = 0;
        for (int w = 3; w <= CHK_W; w += 2) begin
            for (int v = 0; v < (1 << CHK_W); v++) begin
                if ($countones(v[CHK_W-1:0]) == w && n < DATA_W) begin
                    c[n] = v[CHK_W-1:0];
                    n++;
                end
            end
        end
        return c;
    endfunction

    localparam cols_t HCOLS = hsiao_cols();

    function automatic chk_t hsiao_enc(data_t d);
        chk_t c = '0;
        for (int i = 0; i < DATA_W; i++) begin
            for (int j = 0; j < CHK_W; j++) begin
                if (HCOLS[i][j]) c[j] = c[j] ^ d[i];
            end
        end
        return c;
    endfunction

    function automatic icv_t icv_fold(data_t d);
        logic [HALF_W-1:0] x;
        icv_t r = '0;
        x = d[HALF_W-1:0] ^ d[DATA_W-1:HALF_W];
        for (int k = 0; k < NIB_N; k++) r = r ^ x[k*ICV_W +: ICV_W];
        return r;
    endfunction
endpackage

// File: rtl/flash_rd_ecc_secded.sv
module flash_rd_ecc_secded
    import flash_rd_ecc_pkg::*;
(
    input  data_t data_i,
    input  chk_t  chk_i,
    output data_t data_o,
    output logic  single_o,
    output logic  uncorr_o
);
    chk_t              syn;
    logic [DATA_W-1:0] hit;
    logic              chk_hit;

    assign syn = hsiao_enc(data_i) ^ chk_i;

    // A match with any data column implies an odd-weight syndrome.
    for (genvar i = 0; i < DATA_W; i++) begin : g_col
        assign hit[i] = (syn == HCOLS[i]);
    end

    assign chk_hit = $onehot(syn);

    always_comb begin
        data_o   = data_i ^ hit;
        single_o = (|hit) || chk_hit;
        uncorr_o = (syn != '0) && !single_o;
    end
endmodule

// File: rtl/flash_rd_ecc_icv.sv
module flash_rd_ecc_icv
    import flash_rd_ecc_pkg::*;
(
    input  data_t data_i,
    input  icv_t  icv_i,
    output logic  mismatch_o
);
    assign mismatch_o = (icv_fold(data_i) != icv_i);
endmodule

// File: rtl/flash_rd_ecc_status.sv
module flash_rd_ecc_status #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid_i,
    input  logic              evt_single_i,
    input  logic              evt_bad_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              mode_i,
    input  logic              clr_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              flag_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              alert_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              flag;
        logic [ADDR_W-1:0] addr;
        logic              alert;
        logic              fatal;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt_valid_i && evt_single_i && st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        if (clr_i) st_d.flag = 1'b0;
        if (clr_i && mode_i && !st_q.fatal) st_d.alert = 1'b0;
        if (evt_valid_i && evt_bad_i) begin
            st_d.flag  = 1'b1;
            st_d.alert = 1'b1;
            if (!mode_i) st_d.fatal = 1'b1;
            if (!st_q.flag || clr_i) st_d.addr = addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o   = st_q.cnt;
    assign flag_o  = st_q.flag;
    assign addr_o  = st_q.addr;
    assign alert_o = st_q.alert;
endmodule

// File: rtl/flash_rd_ecc.sv
module flash_rd_ecc
    import flash_rd_ecc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              ecc_en,
    input  logic [63:0]       raw_data,
    input  logic [7:0]        raw_chk,
    input  logic [3:0]        raw_icv,
    input  logic              alert_mode,
    input  logic              sw_clr,
    output logic              rsp_valid,
    output logic [63:0]       rsp_data,
    output logic              rsp_err,
    output logic              alert,
    output logic [CNT_W-1:0]  corr_cnt,
    output logic              uncorr_flag,
    output logic [ADDR_W-1:0] err_addr
);
    typedef struct packed {
        logic  valid;
        logic  err;
        data_t data;
    } rsp_t;

    rsp_t  rsp_d, rsp_q;
    data_t fixed;
    logic  single, uncorr, icv_bad, bad, evt_valid;

    flash_rd_ecc_secded u_secded (
        .data_i   (raw_data),
        .chk_i    (raw_chk),
        .data_o   (fixed),
        .single_o (single),
        .uncorr_o (uncorr)
    );

    flash_rd_ecc_icv u_icv (
        .data_i     (fixed),
        .icv_i      (raw_icv),
        .mismatch_o (icv_bad)
    );

    assign bad       = uncorr || icv_bad;
    assign evt_valid = rd_valid && ecc_en;

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = rd_valid;
        rsp_d.err   = evt_valid && bad;
        if (rd_valid) begin
            if (!ecc_en)  rsp_d.data = raw_data;
            else if (bad) rsp_d.data = '0;
            else          rsp_d.data = fixed;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    flash_rd_ecc_status #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_valid_i  (evt_valid),
        .evt_single_i (single),
        .evt_bad_i    (bad),
        .addr_i       (rd_addr),
        .mode_i       (alert_mode),
        .clr_i        (sw_clr),
        .cnt_o        (corr_cnt),
        .flag_o       (uncorr_flag),
        .addr_o       (err_addr),
        .alert_o      (alert)
    );

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_data  = rsp_q.data;
endmodule

// File: rtl/flash_rd_ecc_chk.sv
module flash_rd_ecc_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic              ecc_en,
    input logic [63:0]       raw_data,
    input logic              alert_mode,
    input logic              sw_clr,
    input logic              rsp_valid,
    input logic [63:0]       rsp_data,
    input logic              rsp_err,
    input logic              alert,
    input logic [CNT_W-1:0]  corr_cnt,
    input logic              uncorr_flag,
    input logic [ADDR_W-1:0] err_addr
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rsp_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !rsp_valid && !rsp_err);
    a_r3_err_alerts: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> alert && uncorr_flag);
    a_r4_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !ecc_en |=> rsp_data == $past(raw_data) && !rsp_err);
    a_r6_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        alert && !alert_mode |=> alert);
    a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        uncorr_flag && sw_clr && !rd_valid |=> !uncorr_flag);
    a_r9_cnt_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> corr_cnt >= $past(corr_cnt));
    a_r9_cnt_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        corr_cnt == CNT_MAX |=> corr_cnt == CNT_MAX);
    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        uncorr_flag && !sw_clr |=> $stable(err_addr));
endmodule

bind flash_rd_ecc flash_rd_ecc_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_valid    (rd_valid),
    .ecc_en      (ecc_en),
    .raw_data    (raw_data),
    .alert_mode  (alert_mode),
    .sw_clr      (sw_clr),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .rsp_err     (rsp_err),
    .alert       (alert),
    .corr_cnt    (corr_cnt),
    .uncorr_flag (uncorr_flag),
    .err_addr    (err_addr)
);

// File: tb/sim_flash_rd_ecc.sv
`timescale 1ns/1ps
module sim_flash_rd_ecc;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_valid = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          ecc_en = 1'b0;
    logic [63:0]   raw_data = '0;
    logic [7:0]    raw_chk = '0;
    logic [3:0]    raw_icv = '0;
    logic          alert_mode = 1'b0;
    logic          sw_clr = 1'b0;
    logic          rsp_valid, rsp_err, alert, uncorr_flag;
    logic [63:0]   rsp_data;
    logic [7:0]    corr_cnt;
    logic [AW-1:0] err_addr;

    flash_rd_ecc #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .ecc_en(ecc_en), .raw_data(raw_data), .raw_chk(raw_chk), .raw_icv(raw_icv),
        .alert_mode(alert_mode), .sw_clr(sw_clr), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_err(rsp_err), .alert(alert), .corr_cnt(corr_cnt),
        .uncorr_flag(uncorr_flag), .err_addr(err_addr)
    );

    always #5 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R11";

    // Reference model state
    logic          e_valid, e_err, e_alert, e_flag, e_fatal;
    logic [63:0]   e_data;
    logic [AW-1:0] e_addr;
    int            e_cnt;
    logic [7:0]    mcol [64];

    task automatic build_cols();
        logic [7:0] q3[$];
        logic [7:0] q5[$];
        for (int v = 0; v < 256; v++) begin
            if ($countones(v[7:0]) == 3) q3.push_back(v[7:0]);
            if ($countones(v[7:0]) == 5) q5.push_back(v[7:0]);
        end
        for (int i = 0; i < 64; i++) mcol[i] = (i < q3.size()) ? q3[i] : q5[i - q3.size()];
    endtask

    function automatic logic [7:0] m_enc(logic [63:0] d);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < 64; i++) if (d[i]) c = c ^ mcol[i];
        return c;
    endfunction

    function automatic logic [3:0] m_icv(logic [63:0] d);
        logic [31:0] x = d[31:0] ^ d[63:32];
        logic [3:0]  r = 4'h0;
        for (int k = 0; k < 8; k++) r = r ^ 4'(x >> (4 * k));
        return r;
    endfunction

    // Brute-force search for the single flipped bit among 72.
    task automatic m_decode(input logic [63:0] d, input logic [7:0] c, input logic [3:0] iv,
                            output logic [63:0] dout, output bit single, output bit bad);
        single = 0;
        bad    = 0;
        dout   = d;
        if (m_enc(d) != c) begin
            bad = 1;
            for (int p = 0; p < 72; p++) begin
                logic [71:0] w = {c, d} ^ (72'd1 << p);
                if (bad && m_enc(w[63:0]) == w[71:64]) begin
                    dout   = w[63:0];
                    single = 1;
                    bad    = 0;
                end
            end
        end
        if (!bad && m_icv(dout) != iv) bad = 1;
    endtask

    task automatic m_reset();
        e_valid = 0; e_err = 0; e_alert = 0; e_flag = 0; e_fatal = 0;
        e_data = '0; e_addr = '0; e_cnt = 0;
    endtask

    task automatic m_step();
        logic [63:0] dd;
        bit          s, b, ev, old_flag, old_fatal;
        if (!rst_n) begin
            m_reset();
            return;
        end
        m_decode(raw_data, raw_chk, raw_icv, dd, s, b);
        ev      = rd_valid && ecc_en;
        e_valid = rd_valid;
        e_err   = ev && b;
        if (rd_valid) e_data = !ecc_en ? raw_data : (b ? 64'd0 : dd);
        if (ev && s && e_cnt < 255) e_cnt++;
        old_flag  = e_flag;
        old_fatal = e_fatal;
        if (sw_clr) e_flag = 0;
        if (sw_clr && alert_mode && !old_fatal) e_alert = 0;
        if (ev && b) begin
            e_flag  = 1;
            e_alert = 1;
            if (!alert_mode) e_fatal = 1;
            if (!old_flag || sw_clr) e_addr = rd_addr;
        end
    endtask

    task automatic check(string name, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, name, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        m_step();
        #1;
        check("rsp_valid", 64'(rsp_valid), 64'(e_valid));
        check("rsp_data", rsp_data, e_data);
        check("rsp_err", 64'(rsp_err), 64'(e_err));
        check("alert", 64'(alert), 64'(e_alert));
        check("uncorr_flag", 64'(uncorr_flag), 64'(e_flag));
        check("err_addr", 64'(err_addr), 64'(e_addr));
        check("corr_cnt", 64'(corr_cnt), 64'(e_cnt));
        rd_valid = 0;
        sw_clr   = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        tag = "R11";
        step();
        step();
        rst_n = 1;
    endtask

    // flip: bits of {chk,data} to invert; icv_ok: integrity over original data
    task automatic rd(logic [AW-1:0] a, logic [63:0] d, logic [71:0] flip, bit en, bit icv_ok);
        logic [71:0] w = {m_enc(d), d} ^ flip;
        rd_valid = 1;
        rd_addr  = a;
        ecc_en   = en;
        raw_data = w[63:0];
        raw_chk  = w[71:64];
        raw_icv  = icv_ok ? m_icv(d) : ~m_icv(d);
        step();
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        build_cols();
        m_reset();
        do_reset();
        step();

        tag = "R1";
        rd(16'h0010, rnd64(), '0, 1, 1);
        step();
        rd(16'h0011, rnd64(), '0, 1, 1);
        rd(16'h0012, 64'hFFFF_0000_A5A5_5A5A, '0, 1, 1);

        tag = "R2";
        rd(16'h0020, rnd64(), 72'd1, 1, 1);
        rd(16'h0021, rnd64(), 72'd1 << 63, 1, 1);
        rd(16'h0022, rnd64(), 72'd1 << 64, 1, 1);
        rd(16'h0023, rnd64(), 72'd1 << 71, 1, 1);
        for (int i = 0; i < 8; i++) rd(16'h0030, rnd64(), 72'd1 << ($urandom % 72), 1, 1);

        tag = "R5";
        rd(16'h0040, rnd64(), 72'd1 << 17, 1, 1);
        rd(16'h0041, rnd64(), '0, 1, 0);
        do_reset();

        tag = "R4";
        rd(16'h0050, rnd64(), 72'h3, 0, 0);
        rd(16'h0051, rnd64(), 72'd1 << 5, 0, 1);
        step();

        tag = "R3";
        rd(16'h0060, rnd64(), 72'h3, 1, 1);
        rd(16'h0061, rnd64(), (72'd1 << 70) | 72'd1 << 2, 1, 1);
        tag = "R10";
        rd(16'h0062, rnd64(), 72'h6, 1, 1);
        step();

        tag = "R6";
        sw_clr = 1;
        step();
        rd(16'h0063, rnd64(), '0, 1, 1);
        rd(16'h0064, rnd64(), 72'd1 << 9, 1, 1);
        alert_mode = 1;
        sw_clr = 1;
        step();
        alert_mode = 0;

        do_reset();
        alert_mode = 1;
        tag = "R7";
        rd(16'h0070, rnd64(), 72'h5, 1, 1);
        step();
        sw_clr = 1;
        step();
        step();
        tag = "R8";
        rd(16'h0071, rnd64(), '0, 1, 0);
        sw_clr = 1;
        rd(16'h0072, rnd64(), 72'h9, 1, 1);
        tag = "R10";
        rd(16'h0073, rnd64(), 72'h9, 1, 1);
        sw_clr = 1;
        step();
        rd(16'h0074, rnd64(), 72'h30, 1, 1);
        alert_mode = 0;

        tag = "R9";
        for (int i = 0; i < 260; i++) rd(AW'(i), rnd64(), 72'd1 << (i % 72), 1, 1);
        rd(16'h0080, rnd64(), 72'd1 << 3, 1, 1);
        step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule